// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog for a small microcontroller. It is off after reset and stays off until software writes a two-byte key into its service register: first 8'h1E, then 8'hE1. After that it cannot be switched off by any register write. Only a reset stops it again. Writing the same key while the watchdog runs restarts the count. If software fails to do so in time, the watchdog raises a reset pulse of fixed length on its output, and this pulse is meant to reset the whole chip.

The period is a power of two above a divide-by-six prescaler. A 3-bit exponent in a program register selects the power of two. An exponent change takes effect at the next restart of the count. The count runs on every oscillator cycle or on every second one. The choice depends on the clock-doubling mode and a select bit. Idle status has no effect on the count. Power-down status freezes the count, and counting resumes from the frozen value when power-down ends.

Top module: `seqwdt_top`

## Requirements
- R1: After reset the watchdog is disarmed, its count is zero and `wdt_rst_o` is low.
- R2: A write of 8'h1E followed by a write of 8'hE1 to the service port arms the watchdog. Cycles without writes may separate the two writes, but no other write may come between them. The arming write counts as count cycle 0.
- R3: Once the watchdog is armed, no service write or program write disarms it. Only `rst_n` disarms it.
- R4: The time-out, in count ticks after the arming or clearing write, is PRE_DIV × 2^(BASE_EXP + WTO). WTO is the 3-bit program value. The defaults give 6 × 2^14 × 2^WTO.
- R5: A count tick occurs on every clock cycle when `dbl_speed`=1 and `slow_sel`=0. In every other case a tick occurs on every second cycle. `wdt_rst_o` rises after T×1 or T×2 clock edges respectively.
- R6: On overflow, `wdt_rst_o` is high for exactly PULSE_LEN clock cycles (default 96). The watchdog is then disarmed and stays silent until it is armed again.
- R7: `idle_st` has no effect on counting or on time-out.
- R8: While `pdown_st`=1 the count is frozen, and afterwards it resumes from the held value.
- R9: A reset given during power-down clears the count and disarms the watchdog.
- R10: Any write other than 8'hE1 right after 8'h1E voids the sequence. A new sequence must start with 8'h1E.
- R11: The key sequence written while the watchdog is armed restarts the count from zero.
- R12: A program write of WTO while the watchdog counts does not change the current period. The new WTO applies from the next arming or clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| svc_wr | input | 1 | Service register write strobe |
| svc_data | input | 8 | Service register write data |
| prog_wr | input | 1 | Program register write strobe |
| prog_wto | input | 3 | Period exponent WTO |
| dbl_speed | input | 1 | Clock-doubling mode active |
| slow_sel | input | 1 | Select bit: forces half-rate count in doubling mode |
| idle_st | input | 1 | Idle mode status |
| pdown_st | input | 1 | Power-down mode status |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions are checked on every cycle:
- a disarmed watchdog holds a zero count, and an armed one stays armed until it overflows;
- the counter never passes its programmed limit;
- power-down freezes both the prescaler and the counter, while idle status still lets the tick phase advance;
- every reset pulse starts exactly one cycle after an overflow.

Only the bench scenarios can show the timing from end to end. They measure the exact time-out in both count-clock modes and the 96-cycle pulse length. They also show that voided key sequences leave the state alone, that a reset inside power-down disarms the watchdog, and that a WTO change is held back until the next clear.

// File: rtl/seqwdt_pkg.sv
package seqwdt_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  // number of prescaled ticks in one period for a given exponent
  function automatic int unsigned wdt_span(input int unsigned base_exp,
                                           input logic [2:0] wto);
    return 32'd1 << (base_exp + int'(wto));
  endfunction

  // count clock runs at full oscillator rate only in doubling mode with select clear
  function automatic logic wdt_fast(input logic dbl, input logic sel);
    return dbl & ~sel;
  endfunction
endpackage

// File: rtl/seqwdt_key.sv
module seqwdt_key
  import seqwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] data,
  output logic       fire
);
  logic got_first_q;

  assign fire = wr && got_first_q && (data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   got_first_q <= 1'b0;
    else if (wr)  got_first_q <= (data == KEY_FIRST);
  end
endmodule

// File: rtl/seqwdt_clkdiv.sv
module seqwdt_clkdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic fast,
  output logic tick,
  output logic phase
);
  logic ph_q;

  assign tick  = run && (fast || ph_q);
  assign phase = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= 1'b0;
    else if (clear)  ph_q <= 1'b0;
    else if (run)    ph_q <= ~ph_q;
  end
endmodule

// File: rtl/seqwdt_core.sv
module seqwdt_core
  import seqwdt_pkg::*;
#(
  parameter int unsigned PRE_DIV  = 6,
  parameter int unsigned BASE_EXP = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       tick,
  input  logic       pdown,
  input  logic [2:0] wto_prog,
  output logic       armed,
  output logic       ovf
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int unsigned CNT_W = BASE_EXP + 7;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic             armed_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       wto_act_q;
  logic             pre_wrap;
  logic [CNT_W-1:0] cnt_last;

  assign cnt_last = CNT_W'(wdt_span(BASE_EXP, wto_act_q) - 1);
  assign pre_wrap = tick && (pre_q == PRE_LAST);
  assign ovf      = armed_q && pre_wrap && (cnt_q == cnt_last) && !fire;
  assign armed    = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
      wto_act_q <= '0;
    end else if (fire) begin
      armed_q   <= 1'b1;
      pre_q     <= '0;
      cnt_q     <= '0;
      wto_act_q <= wto_prog;
    end else if (ovf) begin
      armed_q   <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
    end else if (tick) begin
      if (pre_wrap) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assert_disarmed_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (cnt_q == '0) && (pre_q == '0));
  assert_armed_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ovf) |=> armed_q);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cnt_last);
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !fire) |=> $stable(cnt_q) && $stable(pre_q));
endmodule

// File: rtl/seqwdt_pulse.sv
module seqwdt_pulse #(
  parameter int unsigned PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] left_q;

  assign pulse = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left_q <= '0;
    else if (start)      left_q <= PW'(PULSE_LEN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pulse);
  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(start));
endmodule

// File: rtl/seqwdt_top.sv
module seqwdt_top
  import seqwdt_pkg::*;
#(
  parameter int unsigned PRE_DIV   = 6,
  parameter int unsigned BASE_EXP  = 14,
  parameter int unsigned PULSE_LEN = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  input  logic       prog_wr,
  input  logic [2:0] prog_wto,
  input  logic       dbl_speed,
  input  logic       slow_sel,
  input  logic       idle_st,
  input  logic       pdown_st,
  output logic       wdt_rst_o
);
  logic       fire, armed, ovf, tick, phase, run;
  logic [2:0] wto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wto_q <= '0;
    else if (prog_wr) wto_q <= prog_wto;
  end

  assign run = armed && !pdown_st;

  seqwdt_key u_key (
    .clk(clk), .rst_n(rst_n), .wr(svc_wr), .data(svc_data), .fire(fire));

  seqwdt_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .clear(fire), .run(run),
    .fast(wdt_fast(dbl_speed, slow_sel)), .tick(tick), .phase(phase));

  seqwdt_core #(.PRE_DIV(PRE_DIV), .BASE_EXP(BASE_EXP)) u_core (
    .clk(clk), .rst_n(rst_n), .fire(fire), .tick(tick), .pdown(pdown_st),
    .wto_prog(wto_q), .armed(armed), .ovf(ovf));

  seqwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(ovf), .pulse(wdt_rst_o));

  assert_idle_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_st && armed && !pdown_st && !fire) |=> (phase != $past(phase)));
endmodule

// File: tb/sim_seqwdt_top.sv
`timescale 1ns/1ps
module sim_seqwdt_top;
  localparam int PRE = 6, BEXP = 3, PLEN = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic svc_wr = 0, prog_wr = 0, dbl_speed = 0, slow_sel = 0, idle_st = 0, pdown_st = 0;
  logic [7:0] svc_data = 0;
  logic [2:0] prog_wto = 0;
  logic wdt_rst_o;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  seqwdt_top #(.PRE_DIV(PRE), .BASE_EXP(BEXP), .PULSE_LEN(PLEN)) u0 (
    .clk, .rst_n, .svc_wr, .svc_data, .prog_wr, .prog_wto, .dbl_speed,
    .slow_sel, .idle_st, .pdown_st, .wdt_rst_o);

  function automatic int tmo(input int w, input logic d, input logic s);
    return PRE * (1 << (BEXP + w)) * ((d && !s) ? 1 : 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic svc(input logic [7:0] b);
    svc_wr = 1; svc_data = b; @(negedge clk); svc_wr = 0;
  endtask
  task automatic prog(input logic [2:0] w);
    prog_wr = 1; prog_wto = w; @(negedge clk); prog_wr = 0;
  endtask
  task automatic arm();
    svc(8'h1E); svc(8'hE1);
  endtask
  task automatic run_until(input int lim, output int k);
    int n = 0;
    k = -1;
    while (n < lim) begin
      @(posedge clk); n++; @(negedge clk);
      if (wdt_rst_o) begin k = n; break; end
    end
  endtask
  task automatic pulse_len(output int n);
    n = 1;
    while (wdt_rst_o && n < 1000) begin @(negedge clk); if (wdt_rst_o) n++; end
  endtask
  task automatic do_reset();
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, n, t3, t0;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk("R1 reset output", wdt_rst_o, 0);
    rst_n = 1; @(negedge clk);
    t3 = tmo(3, 0, 0);

    // R1/R10: unarmed, voided or lone keys never time out
    prog(3);
    svc(8'hE1); svc(8'h1E); svc(8'h55); svc(8'hE1);
    run_until(t3 + 50, k);
    chk("R10 void sequence no arm", k, -1);

    // R2/R4/R5/R6 half rate, then pulse length and disarm
    arm();
    run_until(t3 + 50, k);
    chk("R4 timeout half rate", k, t3);
    pulse_len(n);
    chk("R6 pulse length", n, PLEN);
    run_until(t3 + 50, k);
    chk("R6 disarmed after pulse", k, -1);

    // R5 fast count clock
    dbl_speed = 1; slow_sel = 0;
    arm();
    run_until(t3 + 50, k);
    chk("R5 fast rate", k, tmo(3, 1, 0));
    pulse_len(n);
    // R5 doubling mode with select set is half rate
    slow_sel = 1;
    arm();
    run_until(t3 + 50, k);
    chk("R5 select forces half rate", k, tmo(3, 1, 1));
    pulse_len(n);
    slow_sel = 0;
    t3 = tmo(3, 1, 0);

    // R3: other writes do not disarm
    arm(); svc(8'h00); svc(8'hFF); svc(8'h1E); svc(8'h00); prog(1);
    run_until(t3 + 50, k);
    chk("R3 cannot disarm", k, t3 - 5);
    pulse_len(n);

    // R11 service clears, R10 void service does not
    arm();
    repeat (40) @(negedge clk);
    arm();
    run_until(t3 + 50, k);
    chk("R11 service restarts count", k, tmo(1, 1, 0));
    pulse_len(n);
    prog(3);
    arm();
    repeat (20) @(negedge clk);
    svc(8'h1E); svc(8'h55); svc(8'hE1);
    run_until(t3 + 50, k);
    chk("R10 void service keeps count", k, t3 - 23);
    pulse_len(n);

    // R12: WTO change waits for next clear
    arm();
    repeat (10) @(negedge clk);
    prog(0);
    run_until(t3 + 50, k);
    chk("R12 period kept mid count", k, t3 - 11);
    pulse_len(n);
    t0 = tmo(0, 1, 0);
    arm();
    run_until(t3 + 50, k);
    chk("R12 new period after clear", k, t0);
    pulse_len(n);

    // R8: power-down freezes and resumes
    prog(3);
    arm();
    repeat (30) @(negedge clk);
    pdown_st = 1;
    repeat (200) @(negedge clk);
    chk("R8 no pulse in power-down", wdt_rst_o, 0);
    pdown_st = 0;
    run_until(t3 + 300, k);
    chk("R8 resume from held count", k, t3 - 30);
    pulse_len(n);

    // R9: reset during power-down disarms and clears
    arm();
    repeat (100) @(negedge clk);
    pdown_st = 1; @(negedge clk);
    do_reset();
    pdown_st = 0;
    chk("R9 output low after reset", wdt_rst_o, 0);
    dbl_speed = 1; prog(3);
    run_until(t3 + 50, k);
    chk("R9 disarmed after reset", k, -1);
    arm();
    run_until(t3 + 50, k);
    chk("R9 count cleared", k, t3);
    pulse_len(n);

    // random mix (R4 R5 R7)
    for (int i = 0; i < 12; i++) begin
      logic [2:0] w;
      w = 3'($urandom % 4);
      dbl_speed = 1'($urandom); slow_sel = 1'($urandom); idle_st = 1'($urandom);
      prog(w);
      arm();
      run_until(tmo(w, dbl_speed, slow_sel) + 50, k);
      chk("R7 R4 random timeout", k, tmo(w, dbl_speed, slow_sel));
      pulse_len(n);
      chk("R6 random pulse", n, PLEN);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule